// File: doc/BRIEF.md
# Peripheral Write-Protection Controller

This block holds a write-protect flag, a sticky lock flag and a sticky error flag for each of up to 128 peripherals. Software changes protection by writing a single command word that carries a two-bit action and a seven-bit peripheral index. The decoded command touches exactly one peripheral. A freeze action protects that peripheral and locks it, and only a reset undoes the lock. The command word always reads back as zero.

The protect flags leave the block as a registered vector. Downstream bus logic uses that vector to block writes to protected peripherals. Software reads the flags through a bank selector that presents 32 flags at a time, where peripheral `id` sits in bank `id/32` at bit `id%32`. A command that is refused, either because the target is locked or because the command would not change anything, sets that peripheral's error flag. It also raises a one-cycle refusal pulse. Each error flag is cleared by writing a one to its bit.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset every protect, lock and error flag is 0, `prot_vec` is all zero and `cmd_refused` is low.
- R2: A command is decoded from `cmd_word[17:16]` (action) and `cmd_word[6:0]` (peripheral index). Every other bit, including bits 23:18 and bit 7, has no effect. Action 0 changes nothing, and with `cmd_we` low nothing changes.
- R3: Action 1 (unprotect) on an unlocked, protected peripheral clears its protect flag at the clock edge that samples `cmd_we`.
- R4: Action 2 (protect) on an unlocked, unprotected peripheral sets its protect flag at the clock edge that samples `cmd_we`.
- R5: Action 3 (freeze) on an unlocked peripheral sets both its protect and lock flags, whatever its prior protect state, and is not refused.
- R6: Actions 1, 2 and 3 on a locked peripheral are refused. The protect and lock flags stay unchanged until the next reset, and the peripheral's error flag is set.
- R7: Action 2 on an already protected peripheral, or action 1 on an already unprotected one, is refused. State is unchanged and the error flag is set.
- R8: `cmd_refused` is high for exactly the one cycle after the edge that sampled a refused command, and is low otherwise. `err_any` is the OR of all error flags.
- R9: `prot_bank`, `lock_bank` and `err_bank` show the flags of peripherals 32·`bank_sel` to 32·`bank_sel`+31, with peripheral `id` at bit `id%32`.
- R10: With `err_clr_we` high, each 1 in `err_clr_mask` clears the matching error flag in bank `bank_sel`. If an error is set on the same edge, the set wins.
- R11: `cmd_rdata` is always zero.
- R12: `prot_vec[id]` is a register output equal to peripheral `id`'s protect flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word: action and peripheral index |
| cmd_rdata | output | 32 | Read value of the command word (zero) |
| bank_sel | input | BSEL_W | Bank chosen for readout and error clearing |
| err_clr_we | input | 1 | Error-clear write strobe |
| err_clr_mask | input | 32 | Write-one-to-clear mask for the selected bank |
| prot_bank | output | 32 | Protect flags of the selected bank |
| lock_bank | output | 32 | Lock flags of the selected bank |
| err_bank | output | 32 | Error flags of the selected bank |
| prot_vec | output | NPER | Registered protect flag per peripheral |
| cmd_refused | output | 1 | One-cycle pulse after a refused command |
| err_any | output | 1 | OR of all error flags |

## Verification
A wrong flag in a peripheral's state shows on `prot_vec` and on its bank word in the cycle right after the command edge. A bad lock shows up later: the next unprotect command to that peripheral either goes through or is refused when it should not be. That error is visible one edge after that command, on `cmd_refused` and on the error bank. A bad decode of the index or action moves a flag to the wrong bit position, and a full read of all banks after each command catches it at once.

// File: rtl/wprot_pkg.sv
`timescale 1ns/1ps
package wprot_pkg;
   localparam int WORD_W  = 32;
   localparam int KEY_LSB = 16;
   localparam int ID_BITS = 7;
   localparam int MAX_PER = 1 << ID_BITS;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_UNPROT = 2'd1,
      ACT_PROT   = 2'd2,
      ACT_FREEZE = 2'd3
   } wp_act_e;

   function automatic wp_act_e cmd_action(input logic [WORD_W-1:0] w);
      return wp_act_e'(w[KEY_LSB +: 2]);
   endfunction

   function automatic logic [ID_BITS-1:0] cmd_target(input logic [WORD_W-1:0] w);
      return w[ID_BITS-1:0];
   endfunction
endpackage

// File: rtl/wprot_decode.sv
`timescale 1ns/1ps
module wprot_decode
   import wprot_pkg::*;
#(
   parameter int NPER = 128
) (
   input  logic              cmd_we,
   input  logic [WORD_W-1:0] cmd_word,
   output wp_act_e           act,
   output logic [NPER-1:0]   hit
);
   logic [ID_BITS-1:0] tgt;
   logic               live;
   logic [22:0]        unused_fields;

   assign act  = cmd_action(cmd_word);
   assign tgt  = cmd_target(cmd_word);
   assign live = cmd_we && (act != ACT_NONE);
   assign unused_fields = {cmd_word[31:18], cmd_word[15:7]};

   generate
      if (NPER < WORD_W || NPER > MAX_PER || (NPER % WORD_W) != 0) begin : g_bad_nper
         $error("wprot_decode: NPER must be a multiple of 32 between 32 and 128");
      end
      for (genvar i = 0; i < NPER; i++) begin : g_hit
         assign hit[i] = live && (tgt == ID_BITS'(i));
      end
   endgenerate
endmodule

// File: rtl/wprot_cell.sv
`timescale 1ns/1ps
module wprot_cell
   import wprot_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    hit,
   input  wp_act_e act,
   input  logic    clr_err,
   output logic    prot,
   output logic    lock,
   output logic    err,
   output logic    refuse
);
   logic nxt_prot, nxt_lock;

   always_comb begin
      nxt_prot = prot;
      nxt_lock = lock;
      refuse   = 1'b0;
      if (hit) begin
         if (lock) begin
            refuse = 1'b1;
         end else begin
            case (act)
               ACT_UNPROT: begin
                  if (!prot) refuse = 1'b1;
                  else       nxt_prot = 1'b0;
               end
               ACT_PROT: begin
                  if (prot) refuse = 1'b1;
                  else      nxt_prot = 1'b1;
               end
               ACT_FREEZE: begin
                  nxt_prot = 1'b1;
                  nxt_lock = 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot <= 1'b0;
         lock <= 1'b0;
         err  <= 1'b0;
      end else begin
         prot <= nxt_prot;
         lock <= nxt_lock;
         if (refuse)       err <= 1'b1;
         else if (clr_err) err <= 1'b0;
      end
   end

   AST_LOCK_HOLDS:    assert property (@(posedge clk) disable iff (!rst_n) lock |=> lock);            // R6
   AST_LOCK_FREEZES:  assert property (@(posedge clk) disable iff (!rst_n) lock |=> $stable(prot));   // R6
   AST_LOCK_HAS_PROT: assert property (@(posedge clk) disable iff (!rst_n) lock |-> prot);            // R5
   AST_REFUSE_KEEPS:  assert property (@(posedge clk) disable iff (!rst_n)
                                       refuse |=> (prot == $past(prot)) && err);                      // R7
endmodule

// File: rtl/wprot_bankmux.sv
`timescale 1ns/1ps
module wprot_bankmux
   import wprot_pkg::*;
#(
   parameter int NPER  = 128,
   parameter int SEL_W = 2
) (
   input  logic [NPER-1:0]   flags,
   input  logic [SEL_W-1:0]  sel,
   output logic [WORD_W-1:0] word
);
   localparam int NBANK = NPER / WORD_W;

   logic [WORD_W-1:0] words [NBANK];

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_word
         assign words[b] = flags[b*WORD_W +: WORD_W];
      end
   endgenerate

   always_comb begin
      word = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (sel == SEL_W'(b)) word = words[b];
      end
   end
endmodule

// File: rtl/wprot_ctrl.sv
`timescale 1ns/1ps
module wprot_ctrl
   import wprot_pkg::*;
#(
   parameter int NPER   = 128,
   parameter int BSEL_W = ((NPER / 32) > 1) ? $clog2(NPER / 32) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [31:0]       cmd_word,
   output logic [31:0]       cmd_rdata,
   input  logic [BSEL_W-1:0] bank_sel,
   input  logic              err_clr_we,
   input  logic [31:0]       err_clr_mask,
   output logic [31:0]       prot_bank,
   output logic [31:0]       lock_bank,
   output logic [31:0]       err_bank,
   output logic [NPER-1:0]   prot_vec,
   output logic              cmd_refused,
   output logic              err_any
);
   localparam int NBANK   = NPER / WORD_W;
   localparam int SEL_REQ = (NBANK > 1) ? $clog2(NBANK) : 1;

   generate
      if (BSEL_W != SEL_REQ) begin : g_bad_sel
         $error("wprot_ctrl: BSEL_W does not match NPER");
      end
   endgenerate

   wp_act_e         act;
   logic [NPER-1:0] hit;
   logic [NPER-1:0] prot_q, lock_q, err_q, refuse_v, clr_v;
   logic            refused_q;

   wprot_decode #(.NPER(NPER)) u_dec (
      .cmd_we   (cmd_we),
      .cmd_word (cmd_word),
      .act      (act),
      .hit      (hit)
   );

   generate
      for (genvar i = 0; i < NPER; i++) begin : g_cell
         assign clr_v[i] = err_clr_we && (bank_sel == BSEL_W'(i / WORD_W)) && err_clr_mask[i % WORD_W];
         wprot_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit[i]),
            .act     (act),
            .clr_err (clr_v[i]),
            .prot    (prot_q[i]),
            .lock    (lock_q[i]),
            .err     (err_q[i]),
            .refuse  (refuse_v[i])
         );
      end
   endgenerate

   wprot_bankmux #(.NPER(NPER), .SEL_W(BSEL_W)) u_prot_mux (
      .flags (prot_q), .sel (bank_sel), .word (prot_bank));
   wprot_bankmux #(.NPER(NPER), .SEL_W(BSEL_W)) u_lock_mux (
      .flags (lock_q), .sel (bank_sel), .word (lock_bank));
   wprot_bankmux #(.NPER(NPER), .SEL_W(BSEL_W)) u_err_mux (
      .flags (err_q),  .sel (bank_sel), .word (err_bank));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) refused_q <= 1'b0;
      else        refused_q <= |refuse_v;
   end

   assign prot_vec    = prot_q;
   assign cmd_refused = refused_q;
   assign err_any     = |err_q;
   assign cmd_rdata   = '0;

   AST_IDLE_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) !cmd_we |=> $stable(prot_vec));  // R2
   AST_IDLE_NO_REF:   assert property (@(posedge clk) disable iff (!rst_n) !cmd_we |=> !cmd_refused);      // R8
   AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
                                       1'b1 |=> ($countones(prot_vec ^ $past(prot_vec)) <= 1));            // R2
   AST_REFUSE_FLAGS:  assert property (@(posedge clk) disable iff (!rst_n) cmd_refused |-> err_any);       // R6
endmodule

// File: tb/wprot_ctrl_test.sv
`timescale 1ns/1ps
module wprot_ctrl_test;
   localparam int NP = 128;
   localparam int NB = NP / 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [31:0] cmd_word = '0;
   logic [31:0] cmd_rdata;
   logic [1:0]  bank_sel = '0;
   logic        err_clr_we = 1'b0;
   logic [31:0] err_clr_mask = '0;
   logic [31:0] prot_bank, lock_bank, err_bank;
   logic [NP-1:0] prot_vec;
   logic        cmd_refused, err_any;

   logic [NP-1:0] mprot = '0, mlock = '0, merr = '0;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   wprot_ctrl #(.NPER(NP)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word), .cmd_rdata(cmd_rdata),
      .bank_sel(bank_sel), .err_clr_we(err_clr_we), .err_clr_mask(err_clr_mask),
      .prot_bank(prot_bank), .lock_bank(lock_bank), .err_bank(err_bank),
      .prot_vec(prot_vec), .cmd_refused(cmd_refused), .err_any(err_any)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_state(input string req);
      for (int b = 0; b < NB; b++) begin
         bank_sel = 2'(b);
         #0.5;
         chk(prot_bank == mprot[b*32 +: 32], req, "prot_bank (R9)", prot_bank, mprot[b*32 +: 32]);
         chk(lock_bank == mlock[b*32 +: 32], req, "lock_bank (R9)", lock_bank, mlock[b*32 +: 32]);
         chk(err_bank  == merr[b*32 +: 32],  req, "err_bank (R9)",  err_bank,  merr[b*32 +: 32]);
         chk(prot_vec[b*32 +: 32] == mprot[b*32 +: 32], "R12", "prot_vec slice",
             prot_vec[b*32 +: 32], mprot[b*32 +: 32]);
      end
      chk(err_any == (|merr), "R8", "err_any", 32'(err_any), 32'(|merr));
      chk(cmd_rdata == 32'h0, "R11", "cmd_rdata", cmd_rdata, 32'h0);
   endtask

   function automatic bit model_cmd(input logic [1:0] key, input int id);
      bit r = 1'b0;
      if (key != 2'd0) begin
         if (mlock[id]) r = 1'b1;
         else if (key == 2'd1) begin
            if (!mprot[id]) r = 1'b1; else mprot[id] = 1'b0;
         end else if (key == 2'd2) begin
            if (mprot[id]) r = 1'b1; else mprot[id] = 1'b1;
         end else begin
            mprot[id] = 1'b1;
            mlock[id] = 1'b1;
         end
         if (r) merr[id] = 1'b1;
      end
      return r;
   endfunction

   // Ignored fields are filled with junk to exercise R2 on every command.
   task automatic send(input logic [1:0] key, input int id, input logic [31:0] junk, input string req);
      bit exp_ref;
      exp_ref = model_cmd(key, id);
      @(negedge clk);
      cmd_word = {junk[31:24], junk[13:8], key, junk[15:8], junk[0], 7'(id)};
      cmd_we   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_we = 1'b0;
      chk(cmd_refused == exp_ref, req, "cmd_refused (R8)", 32'(cmd_refused), 32'(exp_ref));
      check_state(req);
      @(negedge clk);
      chk(cmd_refused == 1'b0, "R8", "refusal pulse width", 32'(cmd_refused), 32'h0);
   endtask

   task automatic w1c(input int b, input logic [31:0] m);
      @(negedge clk);
      bank_sel     = 2'(b);
      err_clr_mask = m;
      err_clr_we   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      err_clr_we = 1'b0;
      merr[b*32 +: 32] &= ~m;
      check_state("R10");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      mprot = '0; mlock = '0; merr = '0;
      check_state("R1");
      chk(cmd_refused == 1'b0, "R1", "cmd_refused in reset", 32'(cmd_refused), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1");
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      for (int id = 0; id < NP; id++) begin
         logic [31:0] j;
         j = 32'(id) * 32'h9E3779B1;
         send(2'd2, id, j, "R4");
         send(2'd2, id, ~j, "R7");
         w1c(id / 32, 32'h1 << (id % 32));
         send(2'd1, id, j ^ 32'h00FC_0080, "R3");
         send(2'd1, id, ~j, "R7");
         w1c(id / 32, 32'hFFFF_FFFF);
         send(2'd0, id, 32'hFFFF_FFFF, "R2");
      end
      for (int id = 0; id < NP; id += 2) send(2'd2, id, 32'h00FC_FF80, "R4");
      for (int id = 0; id < NP; id += 3) send(2'd3, id, 32'(id) * 32'h0101_0101, "R5");
      for (int id = 0; id < NP; id += 3) begin
         send(2'd1, id, 32'hA5A5_A5A5, "R6");
         send(2'd2, id, 32'h5A5A_5A5A, "R6");
         send(2'd3, id, 32'hFFFF_FFFF, "R6");
      end
      for (int b = 0; b < NB; b++) w1c(b, 32'hFFFF_FFFF);
      for (int id = 1; id < NP; id += 3) send(2'd1, id, 32'h0, "R3");

      // R10: error set and clear on the same edge, set wins
      begin
         bit r;
         r = model_cmd(2'd2, 0);
         @(negedge clk);
         cmd_word     = {14'h0, 2'd2, 16'h0};
         cmd_we       = 1'b1;
         bank_sel     = 2'd0;
         err_clr_mask = 32'h1;
         err_clr_we   = 1'b1;
         @(posedge clk);
         @(negedge clk);
         cmd_we = 1'b0;
         err_clr_we = 1'b0;
         chk(cmd_refused == r, "R10", "refused on set/clear tie", 32'(cmd_refused), 32'(r));
         check_state("R10");
      end

      do_reset();
      send(2'd1, 0, 32'h0, "R7");
      send(2'd2, 0, 32'h0, "R4");
      send(2'd1, 0, 32'h0, "R3");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule